// File: doc/BRIEF.md
# SDRAM Data-Path Timing Model with Programmable Latency and Burst

This block is a synthesizable behavioural model of the data side of a single-bank SDR SDRAM. On every rising clock edge it samples a two-bit command and an address bus. The commands are no-operation, mode load, read and write. A mode load takes a ten-bit mode word from the address bus, and that word sets the burst length, the burst ordering, the read latency and whether writes burst. Storage is a small internal word array addressed by column.

Read data comes out on a data bus that has a separate output enable. The enable rises one cycle before the first word is valid. The first word then appears a fixed number of cycles after the read edge, two or three as programmed. The rest of the burst follows on consecutive cycles. Write data is sampled at the write edge and, for bursts, on the following edges. A new read or write cuts short the burst in progress. The block is meant for controller benches and for FPGA prototypes that need a memory with realistic read latency.

Top module: `sdram_dq_model`

## Requirements
- R1: After reset, dq_oe_o and mode_err_o are low and dq_o is zero. The mode is latency 2, burst length 1, sequential ordering, and writes follow the burst length.
- R2: The read latency field is mode bits 6:4, where 010 selects 2 and 011 selects 3. For a READ sampled at edge n with latency m, dq_oe_o is high after edge n+m-1 while dq_o is still zero, and the first word is on dq_o after edge n+m.
- R3: The burst length field is mode bits 2:0, where 000, 001, 010 and 011 select 1, 2, 4 and 8 words. A read burst puts its words on consecutive cycles, and dq_oe_o falls on the edge after the last word.
- R4: Mode bit 3 selects the burst ordering. At 0 the column advances sequentially and wraps inside the block aligned to the burst length. At 1 beat k uses the start column's in-block offset XOR k.
- R5: Mode bit 9 controls write bursts. With bit 9 = 0, a WRITE stores wdata_i at the write edge and on the next length-1 edges, in the read ordering. With bit 9 = 1, a WRITE stores only one word while reads still burst.
- R6: A mode load is rejected when bits 8:7 are not 00, when the latency field is not 010 or 011, or when the burst-length field is above 011. A rejected load leaves the mode unchanged and raises mode_err_o for the one cycle after that edge.
- R7: A mode load is rejected in the same way (mode unchanged, mode_err_o pulse) while a read or write burst is being generated or read data is still in flight.
- R8: A READ during a read burst cuts off the old burst's words that have not yet been fetched. The new words follow the latency rule, with no idle cycle when the two bursts meet.
- R9: dq_oe_o is low and dq_o is zero whenever no read data is being presented. A WRITE drops any read output from the cycle after the WRITE edge.
- R10: A READ during a write burst stops it. The READ edge and every later edge of that burst store nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2 | Command: 00 no-op, 01 mode load, 10 read, 11 write |
| addr_i | input | ADDR_W | Column address (low COL_W bits) or mode word |
| wdata_i | input | DATA_W | Write data, sampled on write edges |
| dq_oe_o | output | 1 | Data bus drive enable |
| dq_o | output | DATA_W | Read data, zero when no word is presented |
| mode_err_o | output | 1 | One-cycle pulse after a rejected mode load |

## Verification
The bench goes after the cycle where the enable rises ahead of data at both latencies. A design that is off by one there would drive a word one cycle early or late. It also checks column wrap and XOR ordering at unaligned start columns, where a wrong mask would step out of the aligned block. It checks that a single-location write leaves the neighbouring columns untouched, where a design that ignored bit 9 would overwrite them. Back-to-back reads, reads cut off by a write and writes cut off by a read are checked: a model with a bad flush would leave the bus driven during a write or store stale beats. Busy and illegal mode loads are checked too, where a design that accepted them would shift the latency of the next read.

// File: rtl/sdram_dq_pkg.sv
package sdram_dq_pkg;

   typedef enum logic [1:0] {
      CMD_NOP     = 2'b00,
      CMD_SETMODE = 2'b01,
      CMD_RD      = 2'b10,
      CMD_WR      = 2'b11
   } cmd_e;

   // deepest read latency supported; sizes the read delay line
   localparam int MAX_LAT = 3;
   // beat index width for bursts up to 8 words
   localparam int BEAT_W  = 3;
   // mode word width needed to hold every field
   localparam int MODE_W  = 10;

   typedef struct packed {
      logic       lat3;       // 1: latency 3, 0: latency 2
      logic [3:0] blen;       // burst length in words
      logic       interleave; // XOR ordering
      logic       wr_single;  // writes touch one location
   } mode_t;

   localparam mode_t MODE_RESET = '{lat3: 1'b0, blen: 4'd1, interleave: 1'b0, wr_single: 1'b0};

endpackage

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
   import sdram_dq_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] word_i,
   output mode_t             mode_o,
   output logic              err_o
);

   generate
      if (ADDR_W < MODE_W) begin : g_bad_width
         $error("sdram_mode_reg: ADDR_W must hold the mode word");
      end
   endgenerate

   logic [2:0] lat_code;
   logic       opm_ok, lat_ok, bl_ok, accept;
   mode_t      mode_q;
   logic       err_q;

   always_comb begin
      lat_code = word_i[6:4];
      opm_ok   = (word_i[8:7] == 2'b00);
      lat_ok   = (lat_code == 3'd2) || (lat_code == 3'd3);
      bl_ok    = (word_i[2] == 1'b0);
      accept   = load_i && !busy_i && opm_ok && lat_ok && bl_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         err_q  <= 1'b0;
      end else begin
         err_q <= load_i && !accept;
         if (accept) begin
            mode_q.lat3       <= (lat_code == 3'd3);
            mode_q.blen       <= 4'd1 << word_i[1:0];
            mode_q.interleave <= word_i[3];
            mode_q.wr_single  <= word_i[9];
         end
      end
   end

   assign mode_o = mode_q;
   assign err_o  = err_q;

endmodule

// File: rtl/sdram_burst_gen.sv
module sdram_burst_gen
   import sdram_dq_pkg::*;
#(
   parameter int COL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             skip_i,
   input  logic             stop_i,
   input  logic [COL_W-1:0] col_i,
   input  logic [3:0]       blen_i,
   input  logic             ilv_i,
   output logic             vld_o,
   output logic [COL_W-1:0] col_o
);

   generate
      if (COL_W < BEAT_W) begin : g_bad_col
         $error("sdram_burst_gen: COL_W must cover the longest burst");
      end
   endgenerate

   logic              act_q, ilv_q;
   logic [BEAT_W-1:0] k_q;
   logic [3:0]        len_q;
   logic [COL_W-1:0]  base_q, mask, off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         ilv_q  <= 1'b0;
         k_q    <= '0;
         len_q  <= 4'd1;
         base_q <= '0;
      end else if (start_i) begin
         base_q <= col_i;
         len_q  <= blen_i;
         ilv_q  <= ilv_i;
         k_q    <= skip_i ? BEAT_W'(1) : '0;
         act_q  <= !(skip_i && blen_i == 4'd1);
      end else if (stop_i) begin
         act_q <= 1'b0;
      end else if (act_q) begin
         if ({1'b0, k_q} == len_q - 4'd1) act_q <= 1'b0;
         k_q <= k_q + BEAT_W'(1);
      end
   end

   always_comb begin
      mask  = COL_W'(len_q) - COL_W'(1);
      off   = ilv_q ? (base_q ^ COL_W'(k_q)) : (base_q + COL_W'(k_q));
      col_o = (base_q & ~mask) | (off & mask);
      vld_o = act_q;
   end

endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe
   import sdram_dq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_i,
   input  logic              vld_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              lat3_i,
   output logic              oe_o,
   output logic [DATA_W-1:0] dq_o,
   output logic              busy_o
);

   generate
      if (MAX_LAT != 3) begin : g_bad_lat
         $error("sdram_rd_pipe: tap selection assumes a three-stage line");
      end
   endgenerate

   logic              v_q [MAX_LAT];
   logic [DATA_W-1:0] d_q [MAX_LAT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MAX_LAT; i++) begin
            v_q[i] <= 1'b0;
            d_q[i] <= '0;
         end
      end else begin
         v_q[0] <= vld_i && !flush_i;
         d_q[0] <= data_i;
         for (int i = 1; i < MAX_LAT; i++) begin
            v_q[i] <= v_q[i-1] && !flush_i;
            d_q[i] <= d_q[i-1];
         end
      end
   end

   always_comb begin
      if (lat3_i) begin
         oe_o   = v_q[1] | v_q[2];
         dq_o   = v_q[2] ? d_q[2] : '0;
         busy_o = v_q[0] | v_q[1] | v_q[2];
      end else begin
         oe_o   = v_q[0] | v_q[1];
         dq_o   = v_q[1] ? d_q[1] : '0;
         busy_o = v_q[0] | v_q[1];
      end
   end

endmodule

// File: rtl/sdram_dq_model.sv
module sdram_dq_model
   import sdram_dq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int COL_W  = 5,
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              dq_oe_o,
   output logic [DATA_W-1:0] dq_o,
   output logic              mode_err_o
);

   localparam int DEPTH = 1 << COL_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("sdram_dq_model: DATA_W must be positive");
      end
      if (COL_W > ADDR_W) begin : g_bad_col
         $error("sdram_dq_model: column must fit in the address bus");
      end
   endgenerate

   cmd_e              cmd;
   logic              is_rd, is_wr, is_ld, busy, pipe_busy;
   mode_t             mode;
   logic              rd_vld, wr_vld;
   logic [COL_W-1:0]  rd_col, wr_col, cmd_col;
   logic [3:0]        wr_len;
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rd_data;

   always_comb begin
      cmd     = cmd_e'(cmd_i);
      is_rd   = (cmd == CMD_RD);
      is_wr   = (cmd == CMD_WR);
      is_ld   = (cmd == CMD_SETMODE);
      cmd_col = addr_i[COL_W-1:0];
      wr_len  = mode.wr_single ? 4'd1 : mode.blen;
      busy    = rd_vld | wr_vld | pipe_busy;
      rd_data = mem_q[rd_col];
   end

   sdram_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (is_ld),
      .busy_i (busy),
      .word_i (addr_i),
      .mode_o (mode),
      .err_o  (mode_err_o)
   );

   sdram_burst_gen #(.COL_W(COL_W)) u_rd_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (is_rd),
      .skip_i  (1'b0),
      .stop_i  (is_wr),
      .col_i   (cmd_col),
      .blen_i  (mode.blen),
      .ilv_i   (mode.interleave),
      .vld_o   (rd_vld),
      .col_o   (rd_col)
   );

   sdram_burst_gen #(.COL_W(COL_W)) u_wr_gen (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (is_wr),
      .skip_i  (1'b1),
      .stop_i  (is_rd),
      .col_i   (cmd_col),
      .blen_i  (wr_len),
      .ilv_i   (mode.interleave),
      .vld_o   (wr_vld),
      .col_o   (wr_col)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (is_wr) begin
         mem_q[cmd_col] <= wdata_i;
      end else if (wr_vld && !is_rd) begin
         mem_q[wr_col] <= wdata_i;
      end
   end

   sdram_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (is_wr),
      .vld_i   (rd_vld),
      .data_i  (rd_data),
      .lat3_i  (mode.lat3),
      .oe_o    (dq_oe_o),
      .dq_o    (dq_o),
      .busy_o  (pipe_busy)
   );

endmodule

// File: rtl/sdram_dq_model_chk.sv
module sdram_dq_model_chk
   import sdram_dq_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd_i,
   input logic              dq_oe_o,
   input logic [DATA_W-1:0] dq_o,
   input logic              mode_err_o,
   input logic              busy_i,
   input logic              lat3_i,
   input logic [3:0]        blen_i
);

   // R9
   idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_oe_o |-> dq_o == '0);

   // R2
   lead_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dq_oe_o) |-> dq_o == '0);

   // R2
   lat2_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_RD && !lat3_i) ##1 (cmd_i != CMD_WR) |=> dq_oe_o);

   // R2
   lat3_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_RD && lat3_i) ##1 (cmd_i != CMD_WR) ##1 (cmd_i != CMD_WR) |=> dq_oe_o);

   // R9
   write_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_i == CMD_WR |=> !dq_oe_o);

   // R6
   err_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err_o |-> $past(cmd_i) == CMD_SETMODE);

   // R7
   busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_SETMODE && busy_i) |=> mode_err_o && $stable(lat3_i) && $stable(blen_i));

endmodule

bind sdram_dq_model sdram_dq_model_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_i      (cmd_i),
   .dq_oe_o    (dq_oe_o),
   .dq_o       (dq_o),
   .mode_err_o (mode_err_o),
   .busy_i     (busy),
   .lat3_i     (mode.lat3),
   .blen_i     (mode.blen)
);

// File: tb/sdram_dq_model_bench.sv
module sdram_dq_model_bench;
   import sdram_dq_pkg::*;

   localparam int CLK_NS = 10;
   localparam int DW     = 8;
   localparam int CW     = 5;
   localparam int AW     = 10;
   localparam int NCOL   = 1 << CW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cmd_i = CMD_NOP;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] wdata_i = '0;
   logic          dq_oe_o;
   logic [DW-1:0] dq_o;
   logic          mode_err_o;

   always #(CLK_NS/2) clk = ~clk;

   sdram_dq_model #(.DATA_W(DW), .COL_W(CW), .ADDR_W(AW)) u_sdram_dq_model (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .addr_i(addr_i),
      .wdata_i(wdata_i), .dq_oe_o(dq_oe_o), .dq_o(dq_o), .mode_err_o(mode_err_o)
   );

   // reference model state
   int            cyc = 0;
   int            n_cmp = 0, n_bad = 0;
   bit            done = 0;
   string         req = "R1";
   logic [DW-1:0] mem [NCOL];
   logic [DW-1:0] sched [int];
   bit            errq [int];
   int            m_lat = 2, m_bl = 1;
   bit            m_ilv = 0, m_ws = 0;
   bit            ract = 0, rilv = 0, wact = 0, wilv = 0;
   int            rk, rlen, rstart, wk, wlen, wstart;

   function automatic int bcol(int start, int k, int len, bit ilv);
      int mask = len - 1;
      int off  = ilv ? (start ^ k) : (start + k);
      return ((start & ~mask) | (off & mask)) & (NCOL - 1);
   endfunction

   function automatic logic [AW-1:0] mw(int bl, bit ilv, int lat, bit ws, int opm);
      return AW'((int'(ws) << 9) | (opm << 7) | (lat << 4) | (int'(ilv) << 3) | bl);
   endfunction

   task automatic compare();
      logic [DW-1:0] e_dq = sched.exists(cyc) ? sched[cyc] : '0;
      logic          e_oe = sched.exists(cyc) || sched.exists(cyc + 1);
      logic          e_er = errq.exists(cyc);
      n_cmp++;
      if (dq_oe_o !== e_oe || dq_o !== e_dq || mode_err_o !== e_er) begin
         n_bad++;
         $display("FAIL %s cyc %0d act oe=%b dq=%h err=%b exp oe=%b dq=%h err=%b",
                  req, cyc, dq_oe_o, dq_o, mode_err_o, e_oe, e_dq, e_er);
      end
   endtask

   task automatic model_edge(input logic [1:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
      int e = cyc + 1;
      bit busy = ract || wact;
      int kill [$];
      foreach (sched[k]) if (k >= e - 1) busy = 1;
      if (ract && c != CMD_WR) sched[e + m_lat - 1] = mem[bcol(rstart, rk, rlen, rilv)];
      if (ract) begin
         if (rk == rlen - 1) ract = 0; else rk++;
      end
      if (c == CMD_WR) begin
         mem[int'(a) & (NCOL - 1)] = d;
         foreach (sched[k]) if (k >= e) kill.push_back(k);
         foreach (kill[i]) sched.delete(kill[i]);
         ract = 0;
         wlen = m_ws ? 1 : m_bl;
         wstart = int'(a) & (NCOL - 1);
         wk = 1; wilv = m_ilv; wact = (wlen > 1);
      end else if (c == CMD_RD) begin
         wact = 0;
         ract = 1; rk = 0; rlen = m_bl; rilv = m_ilv;
         rstart = int'(a) & (NCOL - 1);
      end else begin
         if (wact) begin
            mem[bcol(wstart, wk, wlen, wilv)] = d;
            if (wk == wlen - 1) wact = 0; else wk++;
         end
         if (c == CMD_SETMODE) begin
            int lat = (int'(a) >> 4) & 7;
            int bl  = int'(a) & 7;
            if (!busy && ((int'(a) >> 7) & 3) == 0 && (lat == 2 || lat == 3) && bl <= 3) begin
               m_lat = lat; m_bl = 1 << bl;
               m_ilv = a[3]; m_ws = a[9];
            end else begin
               errq[e] = 1;
            end
         end
      end
   endtask

   task automatic tick(input logic [1:0] c, input int a, input int d);
      compare();
      model_edge(c, AW'(a), DW'(d));
      cmd_i = c; addr_i = AW'(a); wdata_i = DW'(d);
      @(posedge clk);
      cyc++;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(CMD_NOP, 0, 8'h5A + i);
   endtask

   task automatic setmode(input logic [AW-1:0] w);
      tick(CMD_SETMODE, int'(w), 0);
      idle(2);
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog act running exp finished");
         finish_run();
      end
   end

   initial begin
      for (int i = 0; i < NCOL; i++) mem[i] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      cyc = 0;

      req = "R1"; idle(3);

      // fill every column with single writes (default burst length 1)
      req = "R5";
      for (int i = 0; i < NCOL; i++) tick(CMD_WR, i, i * 7 + 3);
      idle(2);

      req = "R2"; tick(CMD_RD, 5, 0); idle(4);
      setmode(mw(0, 0, 3, 0, 0));
      req = "R2"; tick(CMD_RD, 9, 0); idle(5);

      req = "R3";
      setmode(mw(1, 0, 2, 0, 0)); tick(CMD_RD, 3, 0); idle(5);
      setmode(mw(2, 0, 3, 0, 0)); tick(CMD_RD, 6, 0); idle(8);
      setmode(mw(3, 0, 2, 0, 0)); tick(CMD_RD, 13, 0); idle(11);

      req = "R4";
      setmode(mw(3, 1, 3, 0, 0)); tick(CMD_RD, 13, 0); idle(12);
      setmode(mw(2, 1, 2, 0, 0)); tick(CMD_RD, 6, 0); idle(7);

      req = "R5";
      setmode(mw(2, 0, 2, 0, 0));
      tick(CMD_WR, 9, 8'hC1); tick(CMD_NOP, 0, 8'hC2); tick(CMD_NOP, 0, 8'hC3); tick(CMD_NOP, 0, 8'hC4);
      idle(1); tick(CMD_RD, 8, 0); idle(7);
      setmode(mw(2, 0, 2, 1, 0));
      tick(CMD_WR, 17, 8'hD1); tick(CMD_NOP, 0, 8'hD2); tick(CMD_NOP, 0, 8'hD3); tick(CMD_NOP, 0, 8'hD4);
      tick(CMD_RD, 16, 0); idle(7);

      req = "R6";
      setmode(mw(2, 0, 3, 1, 1));
      setmode(mw(2, 0, 1, 1, 0));
      setmode(mw(2, 0, 4, 1, 0));
      setmode(mw(4, 0, 3, 1, 0));
      setmode(mw(7, 0, 3, 1, 0));
      tick(CMD_RD, 2, 0); idle(8);

      req = "R7";
      tick(CMD_RD, 0, 0); tick(CMD_SETMODE, int'(mw(3, 0, 3, 0, 0)), 0); idle(6);
      tick(CMD_RD, 20, 0); idle(8);
      setmode(mw(2, 0, 2, 0, 0));
      tick(CMD_WR, 24, 8'hE1); tick(CMD_SETMODE, int'(mw(0, 0, 3, 0, 0)), 8'hE2);
      tick(CMD_NOP, 0, 8'hE3); tick(CMD_NOP, 0, 8'hE4); idle(1);
      tick(CMD_RD, 24, 0); idle(7);

      req = "R8";
      tick(CMD_RD, 1, 0); tick(CMD_NOP, 0, 0); tick(CMD_RD, 10, 0); idle(8);
      tick(CMD_RD, 4, 0); tick(CMD_RD, 12, 0); tick(CMD_RD, 20, 0); idle(8);
      setmode(mw(3, 0, 3, 0, 0));
      tick(CMD_RD, 2, 0); tick(CMD_NOP, 0, 0); tick(CMD_NOP, 0, 0); tick(CMD_RD, 27, 0); idle(12);

      req = "R9";
      tick(CMD_RD, 4, 0); idle(3); tick(CMD_WR, 30, 8'hF1);
      for (int i = 0; i < 7; i++) tick(CMD_NOP, 0, 8'hF2 + i);
      tick(CMD_RD, 24, 0); idle(12);
      setmode(mw(2, 0, 2, 0, 0));
      tick(CMD_RD, 8, 0); tick(CMD_NOP, 0, 0); tick(CMD_WR, 2, 8'h91);
      tick(CMD_NOP, 0, 8'h92); tick(CMD_NOP, 0, 8'h93); tick(CMD_NOP, 0, 8'h94); idle(2);

      req = "R10";
      tick(CMD_WR, 12, 8'hA1); tick(CMD_NOP, 0, 8'hA2); tick(CMD_RD, 12, 8'hA3); idle(6);
      tick(CMD_RD, 14, 8'hA4); idle(6);

      req = "R1"; idle(2);
      finish_run();
   end

endmodule